// File: doc/BRIEF.md
# Partitioned AXI4-Lite Register File

This block is an AXI4-Lite slave that holds a set of data-bus-wide control and status words for user logic. Its register space has three regions that sit back to back. The first is written by software and cannot be read back. The second is written by software and can be read back. The third is driven by hardware and can only be read by software. A parameter sets the size of each region. A region of size zero takes no addresses, so the region after it moves down to fill the gap.

All words that software writes are presented to the user logic at all times on two flat output buses, one for the write-only region and one for the read/write region. The read-only words come in on one flat input bus. Word i of any bus occupies bits [i*DW+DW-1 : i*DW]. Address decoding uses the byte offset divided by the word size in bytes. Any address above the last read-only word is refused with an error response.

Top module: `axil_part_regs`

## Requirements
- R1: Word index is the byte address divided by DATA_W/8, with the low address bits ignored. The write-only words take indices 0 to N_WO-1. The read/write words follow them, and the read-only words come last. A region whose count is zero takes no indices.
- R2: A write changes only the byte lanes whose strobe bit is set. Strobe bit b controls data bits [8b+7:8b].
- R3: The current value of write-only word i is visible on `wo_regs[i*DW +: DW]`, and that of read/write word i on `rw_regs[i*DW +: DW]`. Software writes are the only thing that changes them.
- R4: A read of a write-only word returns zero with response OKAY (2'b00). A read of a read/write word returns the stored value with OKAY.
- R5: A read of a read-only word returns the `ro_regs` slice as it stands in the cycle the read address is accepted. Later changes do not alter a pending response. A write to a read-only word changes nothing and answers OKAY.
- R6: An index at or past N_WO+N_RW+N_RO gets response SLVERR (2'b10). Such a write changes no register, and such a read returns zero data.
- R7: While `aresetn` is low, every write-only and read/write word is zero and every ready and valid output is low.
- R8: The write address and write data may arrive in either order or together. A register changes only once both have been accepted. `s_bvalid` and `s_bresp` then hold until `s_bready`.
- R9: Only one read may be outstanding. `s_arready` stays low while `s_rvalid` is waiting, and `s_rdata` and `s_rresp` stay stable until `s_rready`.
- R10: Only one write may be outstanding. `s_awready` and `s_wready` stay low while `s_bvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| wo_regs | output | max(N_WO,1)*DATA_W | Write-only words, flat |
| rw_regs | output | max(N_RW,1)*DATA_W | Read/write words, flat |
| ro_regs | input | max(N_RO,1)*DATA_W | Read-only words from hardware, flat |

## Verification
The bench builds two copies of the block, both with ADDR_W=8 and DATA_W=32. The first has two words in every region. This reaches all three access classes and the error window starting at index 6, and it allows the word-index slicing to be checked on more than one word. The second has an empty write-only region, one read/write word and one read-only word. This shows that a zero-sized region yields its addresses to the next region and that the error boundary moves down with it.

// File: rtl/axil_regs_pkg.sv
package axil_regs_pkg;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_SLVERR = 2'b10
   } axil_resp_e;

   typedef enum logic [1:0] {
      CLS_WO   = 2'd0,
      CLS_RW   = 2'd1,
      CLS_RO   = 2'd2,
      CLS_NONE = 2'd3
   } reg_class_e;

endpackage

// File: rtl/axil_reg_decode.sv
module axil_reg_decode
   import axil_regs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int N_WO   = 2,
   parameter int N_RW   = 2,
   parameter int N_RO   = 2,
   parameter int IDX_W  = ADDR_W - $clog2(DATA_W / 8)
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_class_e        cls,
   output logic [IDX_W-1:0]  sub
);
   localparam int ADDR_LSB = $clog2(DATA_W / 8);
   localparam int RW_BASE  = N_WO;
   localparam int RO_BASE  = N_WO + N_RW;
   localparam int TOP_IDX  = N_WO + N_RW + N_RO;

   int idx;

   always_comb begin
      idx = int'(addr[ADDR_W-1:ADDR_LSB]);
      cls = CLS_NONE;
      sub = '0;
      if (idx < RW_BASE) begin
         cls = CLS_WO;
         sub = IDX_W'(idx);
      end else if (idx < RO_BASE) begin
         cls = CLS_RW;
         sub = IDX_W'(idx - RW_BASE);
      end else if (idx < TOP_IDX) begin
         cls = CLS_RO;
         sub = IDX_W'(idx - RO_BASE);
      end
   end

endmodule

// File: rtl/axil_wr_chan.sv
module axil_wr_chan
   import axil_regs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int STRB_W = DATA_W / 8
) (
   input  logic              aclk,
   input  logic              aresetn,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic              dec_err,
   output logic              commit,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [STRB_W-1:0] strb_q
);
   logic live;
   logic aw_full;
   logic w_full;

   assign awready = live && !aw_full && !bvalid;
   assign wready  = live && !w_full && !bvalid;
   assign commit  = aw_full && w_full && !bvalid;

   always_ff @(posedge aclk) begin
      if (!aresetn) begin
         live    <= 1'b0;
         aw_full <= 1'b0;
         w_full  <= 1'b0;
         bvalid  <= 1'b0;
         bresp   <= RESP_OKAY;
         addr_q  <= '0;
         data_q  <= '0;
         strb_q  <= '0;
      end else begin
         live <= 1'b1;
         if (awvalid && awready) begin
            aw_full <= 1'b1;
            addr_q  <= awaddr;
         end
         if (wvalid && wready) begin
            w_full <= 1'b1;
            data_q <= wdata;
            strb_q <= wstrb;
         end
         if (commit) begin
            aw_full <= 1'b0;
            w_full  <= 1'b0;
            bvalid  <= 1'b1;
            bresp   <= dec_err ? RESP_SLVERR : RESP_OKAY;
         end else if (bvalid && bready) begin
            bvalid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/axil_rd_chan.sv
module axil_rd_chan
   import axil_regs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              aclk,
   input  logic              aresetn,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic [DATA_W-1:0] rd_word,
   input  logic              dec_err
);
   logic live;

   assign arready = live && !rvalid;

   always_ff @(posedge aclk) begin
      if (!aresetn) begin
         live   <= 1'b0;
         rvalid <= 1'b0;
         rdata  <= '0;
         rresp  <= RESP_OKAY;
      end else begin
         live <= 1'b1;
         if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= dec_err ? '0 : rd_word;
            rresp  <= dec_err ? RESP_SLVERR : RESP_OKAY;
         end else if (rvalid && rready) begin
            rvalid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/axil_reg_bank.sv
module axil_reg_bank
   import axil_regs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int N_WO   = 2,
   parameter int N_RW   = 2,
   parameter int N_RO   = 2,
   parameter int IDX_W  = 6,
   parameter int STRB_W = DATA_W / 8,
   parameter int WO_D   = (N_WO > 0) ? N_WO : 1,
   parameter int RW_D   = (N_RW > 0) ? N_RW : 1,
   parameter int RO_D   = (N_RO > 0) ? N_RO : 1
) (
   input  logic                   aclk,
   input  logic                   aresetn,
   input  logic                   wr_en,
   input  reg_class_e             wr_cls,
   input  logic [IDX_W-1:0]       wr_sub,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [STRB_W-1:0]      wr_strb,
   input  reg_class_e             rd_cls,
   input  logic [IDX_W-1:0]       rd_sub,
   input  logic [RO_D*DATA_W-1:0] ro_in,
   output logic [WO_D*DATA_W-1:0] wo_bus,
   output logic [RW_D*DATA_W-1:0] rw_bus,
   output logic [DATA_W-1:0]      rd_word
);
   logic [WO_D-1:0][DATA_W-1:0] wo_q;
   logic [RW_D-1:0][DATA_W-1:0] rw_q;
   logic [RO_D-1:0][DATA_W-1:0] ro_w;

   assign ro_w   = ro_in;
   assign wo_bus = wo_q;
   assign rw_bus = rw_q;

   if (N_WO > 0) begin : g_wo
      always_ff @(posedge aclk) begin
         if (!aresetn) begin
            wo_q <= '0;
         end else if (wr_en && wr_cls == CLS_WO) begin
            for (int r = 0; r < N_WO; r++) begin
               for (int b = 0; b < STRB_W; b++) begin
                  if (wr_sub == IDX_W'(r) && wr_strb[b])
                     wo_q[r][b*8 +: 8] <= wr_data[b*8 +: 8];
               end
            end
         end
      end
   end else begin : g_wo_none
      assign wo_q = '0;
   end

   if (N_RW > 0) begin : g_rw
      always_ff @(posedge aclk) begin
         if (!aresetn) begin
            rw_q <= '0;
         end else if (wr_en && wr_cls == CLS_RW) begin
            for (int r = 0; r < N_RW; r++) begin
               for (int b = 0; b < STRB_W; b++) begin
                  if (wr_sub == IDX_W'(r) && wr_strb[b])
                     rw_q[r][b*8 +: 8] <= wr_data[b*8 +: 8];
               end
            end
         end
      end
   end else begin : g_rw_none
      assign rw_q = '0;
   end

   always_comb begin
      rd_word = '0;
      case (rd_cls)
         CLS_RW: begin
            for (int r = 0; r < N_RW; r++)
               if (rd_sub == IDX_W'(r)) rd_word = rw_q[r];
         end
         CLS_RO: begin
            for (int r = 0; r < N_RO; r++)
               if (rd_sub == IDX_W'(r)) rd_word = ro_w[r];
         end
         default: rd_word = '0;
      endcase
   end

endmodule

// File: rtl/axil_part_regs.sv
module axil_part_regs
   import axil_regs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int N_WO   = 2,
   parameter int N_RW   = 2,
   parameter int N_RO   = 2
) (
   input  logic                                       aclk,
   input  logic                                       aresetn,
   input  logic [ADDR_W-1:0]                          s_awaddr,
   input  logic                                       s_awvalid,
   output logic                                       s_awready,
   input  logic [DATA_W-1:0]                          s_wdata,
   input  logic [DATA_W/8-1:0]                        s_wstrb,
   input  logic                                       s_wvalid,
   output logic                                       s_wready,
   output logic [1:0]                                 s_bresp,
   output logic                                       s_bvalid,
   input  logic                                       s_bready,
   input  logic [ADDR_W-1:0]                          s_araddr,
   input  logic                                       s_arvalid,
   output logic                                       s_arready,
   output logic [DATA_W-1:0]                          s_rdata,
   output logic [1:0]                                 s_rresp,
   output logic                                       s_rvalid,
   input  logic                                       s_rready,
   output logic [((N_WO > 0) ? N_WO : 1)*DATA_W-1:0]  wo_regs,
   output logic [((N_RW > 0) ? N_RW : 1)*DATA_W-1:0]  rw_regs,
   input  logic [((N_RO > 0) ? N_RO : 1)*DATA_W-1:0]  ro_regs
);
   localparam int STRB_W   = DATA_W / 8;
   localparam int ADDR_LSB = $clog2(STRB_W);
   localparam int IDX_W    = ADDR_W - ADDR_LSB;
   localparam int TOTAL    = N_WO + N_RW + N_RO;

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("axil_part_regs: DATA_W must be 32 or 64");
   end
   if (N_WO < 0 || N_RW < 0 || N_RO < 0 || TOTAL == 0) begin : g_bad_count
      $error("axil_part_regs: region counts must be non-negative and not all zero");
   end
   if (TOTAL > (1 << IDX_W)) begin : g_bad_addr
      $error("axil_part_regs: ADDR_W too small for the register count");
   end

   logic [ADDR_W-1:0] wr_addr_q;
   logic [DATA_W-1:0] wr_data_q;
   logic [STRB_W-1:0] wr_strb_q;
   logic              wr_commit;
   reg_class_e        wr_cls;
   reg_class_e        rd_cls;
   logic [IDX_W-1:0]  wr_sub;
   logic [IDX_W-1:0]  rd_sub;
   logic [DATA_W-1:0] rd_word;

   axil_reg_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .N_WO(N_WO), .N_RW(N_RW), .N_RO(N_RO), .IDX_W(IDX_W)
   ) u_wdec (
      .addr(wr_addr_q), .cls(wr_cls), .sub(wr_sub)
   );

   axil_reg_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .N_WO(N_WO), .N_RW(N_RW), .N_RO(N_RO), .IDX_W(IDX_W)
   ) u_rdec (
      .addr(s_araddr), .cls(rd_cls), .sub(rd_sub)
   );

   axil_wr_chan #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_W(STRB_W)
   ) u_wr (
      .aclk(aclk), .aresetn(aresetn),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .dec_err(wr_cls == CLS_NONE), .commit(wr_commit),
      .addr_q(wr_addr_q), .data_q(wr_data_q), .strb_q(wr_strb_q)
   );

   axil_rd_chan #(
      .DATA_W(DATA_W)
   ) u_rd (
      .aclk(aclk), .aresetn(aresetn),
      .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .rd_word(rd_word), .dec_err(rd_cls == CLS_NONE)
   );

   axil_reg_bank #(
      .DATA_W(DATA_W), .N_WO(N_WO), .N_RW(N_RW), .N_RO(N_RO),
      .IDX_W(IDX_W), .STRB_W(STRB_W)
   ) u_bank (
      .aclk(aclk), .aresetn(aresetn),
      .wr_en(wr_commit), .wr_cls(wr_cls), .wr_sub(wr_sub),
      .wr_data(wr_data_q), .wr_strb(wr_strb_q),
      .rd_cls(rd_cls), .rd_sub(rd_sub), .ro_in(ro_regs),
      .wo_bus(wo_regs), .rw_bus(rw_regs), .rd_word(rd_word)
   );

endmodule

// File: rtl/axil_part_regs_chk.sv
module axil_part_regs_chk #(
   parameter int DATA_W = 32,
   parameter int WO_W   = 64,
   parameter int RW_W   = 64
) (
   input logic              aclk,
   input logic              aresetn,
   input logic              awready,
   input logic              wready,
   input logic              arready,
   input logic              bvalid,
   input logic              bready,
   input logic [1:0]        bresp,
   input logic              rvalid,
   input logic              rready,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        rresp,
   input logic [WO_W-1:0]   wo_regs,
   input logic [RW_W-1:0]   rw_regs
);

   AST_BVALID_HOLD: assert property (@(posedge aclk) disable iff (!aresetn)
      bvalid && !bready |=> bvalid && $stable(bresp)); // R8

   AST_RVALID_HOLD: assert property (@(posedge aclk) disable iff (!aresetn)
      rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp)); // R9

   AST_AR_BLOCKED: assert property (@(posedge aclk) disable iff (!aresetn)
      rvalid |-> !arready); // R9

   AST_W_BLOCKED: assert property (@(posedge aclk) disable iff (!aresetn)
      bvalid |-> !awready && !wready); // R10

   AST_REGS_ONLY_ON_COMMIT: assert property (@(posedge aclk) disable iff (!aresetn)
      !$rose(bvalid) |-> $stable(rw_regs) && $stable(wo_regs)); // R3

   AST_ERR_READ_ZERO: assert property (@(posedge aclk) disable iff (!aresetn)
      rvalid && rresp == 2'b10 |-> rdata == '0); // R6

endmodule

bind axil_part_regs axil_part_regs_chk #(
   .DATA_W(DATA_W),
   .WO_W(((N_WO > 0) ? N_WO : 1) * DATA_W),
   .RW_W(((N_RW > 0) ? N_RW : 1) * DATA_W)
) u_chk (
   .aclk(aclk), .aresetn(aresetn),
   .awready(s_awready), .wready(s_wready), .arready(s_arready),
   .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
   .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
   .wo_regs(wo_regs), .rw_regs(rw_regs)
);

// File: tb/axil_part_regs_tb_top.sv
module axil_part_regs_tb_top;

   logic clk = 1'b0;
   logic aresetn = 1'b0;
   always #5 clk = ~clk;

   int n_checks = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic        sel = 1'b0;
   logic [7:0]  awaddr = '0, araddr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
   logic        bready = 1'b0, rready = 1'b0;

   logic        a_awready, a_wready, a_bvalid, a_arready, a_rvalid;
   logic [1:0]  a_bresp, a_rresp;
   logic [31:0] a_rdata;
   logic [63:0] a_wo, a_rw;
   logic [63:0] a_ro = {32'hC0DE0005, 32'hC0DE0004};

   logic        z_awready, z_wready, z_bvalid, z_arready, z_rvalid;
   logic [1:0]  z_bresp, z_rresp;
   logic [31:0] z_rdata, z_wo, z_rw;
   logic [31:0] z_ro = 32'hFACE0001;

   logic        awready, wready, bvalid, arready, rvalid;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata;

   assign awready = sel ? z_awready : a_awready;
   assign wready  = sel ? z_wready  : a_wready;
   assign bvalid  = sel ? z_bvalid  : a_bvalid;
   assign bresp   = sel ? z_bresp   : a_bresp;
   assign arready = sel ? z_arready : a_arready;
   assign rvalid  = sel ? z_rvalid  : a_rvalid;
   assign rresp   = sel ? z_rresp   : a_rresp;
   assign rdata   = sel ? z_rdata   : a_rdata;

   axil_part_regs #(.ADDR_W(8), .DATA_W(32), .N_WO(2), .N_RW(2), .N_RO(2)) dut_i (
      .aclk(clk), .aresetn(aresetn),
      .s_awaddr(awaddr), .s_awvalid(awvalid && !sel), .s_awready(a_awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid && !sel), .s_wready(a_wready),
      .s_bresp(a_bresp), .s_bvalid(a_bvalid), .s_bready(bready && !sel),
      .s_araddr(araddr), .s_arvalid(arvalid && !sel), .s_arready(a_arready),
      .s_rdata(a_rdata), .s_rresp(a_rresp), .s_rvalid(a_rvalid), .s_rready(rready && !sel),
      .wo_regs(a_wo), .rw_regs(a_rw), .ro_regs(a_ro)
   );

   axil_part_regs #(.ADDR_W(8), .DATA_W(32), .N_WO(0), .N_RW(1), .N_RO(1)) dut_z (
      .aclk(clk), .aresetn(aresetn),
      .s_awaddr(awaddr), .s_awvalid(awvalid && sel), .s_awready(z_awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid && sel), .s_wready(z_wready),
      .s_bresp(z_bresp), .s_bvalid(z_bvalid), .s_bready(bready && sel),
      .s_araddr(araddr), .s_arvalid(arvalid && sel), .s_arready(z_arready),
      .s_rdata(z_rdata), .s_rresp(z_rresp), .s_rvalid(z_rvalid), .s_rready(rready && sel),
      .wo_regs(z_wo), .rw_regs(z_rw), .ro_regs(z_ro)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_aw(input logic [7:0] a, input int dly);
      repeat (dly) @(negedge clk);
      awaddr = a; awvalid = 1'b1; #1;
      while (!awready) begin @(negedge clk); #1; end
      @(negedge clk); awvalid = 1'b0;
   endtask

   task automatic send_w(input logic [31:0] d, input logic [3:0] s, input int dly);
      repeat (dly) @(negedge clk);
      wdata = d; wstrb = s; wvalid = 1'b1; #1;
      while (!wready) begin @(negedge clk); #1; end
      @(negedge clk); wvalid = 1'b0;
   endtask

   task automatic get_b(output logic [1:0] r);
      bready = 1'b1; #1;
      while (!bvalid) begin @(negedge clk); #1; end
      r = bresp;
      @(negedge clk); bready = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int aw_dly, input int w_dly, output logic [1:0] r);
      fork
         send_aw(a, aw_dly);
         send_w(d, s, w_dly);
      join
      get_b(r);
   endtask

   task automatic send_ar(input logic [7:0] a);
      araddr = a; arvalid = 1'b1; #1;
      while (!arready) begin @(negedge clk); #1; end
      @(negedge clk); arvalid = 1'b0;
   endtask

   task automatic get_r(output logic [31:0] d, output logic [1:0] r);
      rready = 1'b1; #1;
      while (!rvalid) begin @(negedge clk); #1; end
      d = rdata; r = rresp;
      @(negedge clk); rready = 1'b0;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic [1:0] r);
      send_ar(a);
      get_r(d, r);
   endtask

   typedef struct packed {
      logic        is_wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [3:0]  strb;
      logic [31:0] exp;
      logic [1:0]  resp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h08, 32'hA5A5_1234, 4'hF, 32'h0,          2'b00}, // R1 RW word 0
      '{1'b0, 8'h08, 32'h0,         4'h0, 32'hA5A5_1234,  2'b00}, // R4
      '{1'b1, 8'h08, 32'hFFFF_FFFF, 4'h5, 32'h0,          2'b00}, // R2 lanes 0,2
      '{1'b0, 8'h08, 32'h0,         4'h0, 32'hA5FF_12FF,  2'b00}, // R2
      '{1'b1, 8'h00, 32'h1357_9BDF, 4'hF, 32'h0,          2'b00}, // R1 WO word 0
      '{1'b0, 8'h00, 32'h0,         4'h0, 32'h0,          2'b00}, // R4 WO reads zero
      '{1'b0, 8'h04, 32'h0,         4'h0, 32'h0,          2'b00}, // R4
      '{1'b1, 8'h10, 32'hDEAD_BEEF, 4'hF, 32'h0,          2'b00}, // R5 RO write
      '{1'b0, 8'h10, 32'h0,         4'h0, 32'hC0DE_0004,  2'b00}, // R5
      '{1'b0, 8'h17, 32'h0,         4'h0, 32'hC0DE_0005,  2'b00}, // R1 low bits ignored
      '{1'b1, 8'h18, 32'h1234_5678, 4'hF, 32'h0,          2'b10}, // R6
      '{1'b0, 8'h18, 32'h0,         4'h0, 32'h0,          2'b10}, // R6
      '{1'b1, 8'h0C, 32'h1111_1111, 4'h0, 32'h0,          2'b00}  // R2 no strobes
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin : main
      logic [1:0]  r;
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R7 reset state
      check("R7 ready/valid in reset",
            {59'd0, a_awready, a_wready, a_arready, a_bvalid, a_rvalid}, 64'd0);
      check("R7 wo in reset", a_wo, 64'd0);
      check("R7 rw in reset", a_rw, 64'd0);
      aresetn = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) begin
            do_write(VECS[i].addr, VECS[i].data, VECS[i].strb, 0, 0, r);
            check($sformatf("R6/R5 vec %0d bresp", i), 64'(r), 64'(VECS[i].resp));
         end else begin
            do_read(VECS[i].addr, d, r);
            check($sformatf("R4/R5 vec %0d rdata", i), 64'(d), 64'(VECS[i].exp));
            check($sformatf("R6 vec %0d rresp", i), 64'(r), 64'(VECS[i].resp));
         end
      end
      // R3 outputs
      check("R3 wo_regs", a_wo, {32'h0, 32'h1357_9BDF});
      check("R3 rw_regs", a_rw, {32'h0, 32'hA5FF_12FF});

      // R8 address first, data late
      send_aw(8'h0C, 0);
      repeat (3) @(negedge clk);
      check("R8 no commit before data", a_rw[63:32], 64'h0);
      check("R8 no bvalid before data", 64'(bvalid), 64'd0);
      send_w(32'hCAFE_0001, 4'hF, 0);
      get_b(r);
      check("R8 commit after both", a_rw[63:32], 64'hCAFE_0001);
      // R8 data first, address late
      send_w(32'hBEEF_0002, 4'hF, 0);
      repeat (2) @(negedge clk);
      check("R8 no commit before addr", a_wo[63:32], 64'h0);
      send_aw(8'h04, 0);
      get_b(r);
      check("R8 data-first commit", a_wo[63:32], 64'hBEEF_0002);

      // R8/R10 response held
      fork
         send_aw(8'h08, 0);
         send_w(32'h0000_0077, 4'h1, 0);
      join
      repeat (4) @(negedge clk);
      check("R8 bvalid held", 64'(bvalid), 64'd1);
      check("R10 awready/wready low", {62'd0, awready, wready}, 64'd0);
      get_b(r);
      check("R8 bresp okay", 64'(r), 64'd0);
      check("R2 byte 0 only", a_rw[31:0], 64'hA5FF_1277);

      // R9/R5 pending read held, live sampling
      a_ro[31:0] = 32'h0BAD_F00D;
      send_ar(8'h10);
      a_ro[31:0] = 32'h1234_4321;
      repeat (3) @(negedge clk);
      check("R9 arready low while pending", 64'(arready), 64'd0);
      check("R9 rvalid held", 64'(rvalid), 64'd1);
      get_r(d, r);
      check("R5 value at acceptance", 64'(d), 64'h0BAD_F00D);
      do_read(8'h10, d, r);
      check("R5 live value", 64'(d), 64'h1234_4321);

      // R1 second instance: empty write-only region
      sel = 1'b1;
      @(negedge clk);
      do_write(8'h00, 32'h600D_F00D, 4'hF, 1, 0, r);
      check("R1 zero WO -> RW at index 0", 64'(z_rw), 64'h600D_F00D);
      check("R1 zero WO bresp", 64'(r), 64'd0);
      do_read(8'h04, d, r);
      check("R1 zero WO -> RO at index 1", 64'(d), 64'hFACE_0001);
      do_write(8'h08, 32'hFFFF_FFFF, 4'hF, 0, 0, r);
      check("R6 boundary moved down", 64'(r), 64'd2);
      check("R6 no effect", 64'(z_rw), 64'h600D_F00D);
      sel = 1'b0;
      @(negedge clk);

      // R7 reset mid-run
      aresetn = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 wo cleared", a_wo, 64'd0);
      check("R7 rw cleared", a_rw, 64'd0);
      check("R7 ready low", {61'd0, a_awready, a_wready, a_arready}, 64'd0);
      aresetn = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule